// File: doc/BRIEF.md
# Serial Link Training Recovery Sequencer

This block watches over the bring-up of a multi-lane serial port once its SERDES has come out of reset. When `start` is pulsed, it first checks the reset-done flag. It then polls the port's initialized status for a bounded window and decides whether training succeeded.

A port configured as one lane is good as soon as it reports initialized. A port configured as four lanes is good only if it is initialized and also reports the full four-lane trained width. Training down to a narrower width counts as a failure.

On failure the block runs a bounded retry loop. Each attempt has these steps:
- hold the port disabled and discard pending outbound traffic;
- pulse the receiver reset of every lane in use, then release it;
- clear the port status register;
- re-enable the port and wait a long settle time before judging again.

Once the port is good, the block waits for the output-error-stopped flag to drop. It then issues clear pulses to the error registers and reports pass with a one-cycle `done`. Every delay is a parameter counted in clock cycles.

Top module: `link_recover_seq`

## Requirements
- R1: After synchronous reset, all outputs (`port_disable`, `ob_discard`, `lane_rx_rst`, `stat_clr`, the three error clears, `done`, `pass`) are 0.
- R2: If `rst_done` is 0 when `start` is sampled, `done` rises with `pass`=0 in the first cycle after that edge, and `port_disable` never asserts.
- R3: With `rst_done`=1, the port status is polled for POLL_CYC cycles. If `port_init` stays 0 for the whole window, `port_disable` first asserts POLL_CYC+1 cycles after the start edge.
- R4: Good means `port_init`=1 and, only when `wide_cfg`=1 (four lanes), also `trained_width`=3'b010. A four-lane port reporting any other width code is sent to recovery, or failed if attempts are exhausted.
- R5: In each recovery attempt, `port_disable` and `ob_discard` rise and fall together and stay high for QUIESCE_CYC+RXRST_CYC+RXREL_CYC+1 cycles. The lane reset is active for RXRST_CYC cycles inside that span.
- R6: In four-lane mode the lane receiver reset drives all four bits (4'b1111). In one-lane mode only bit 0 is driven (4'b0001) and the upper bits stay 0.
- R7: `stat_clr` is a one-cycle pulse in the last cycle of each disabled span. In the following cycle, `port_disable` and `ob_discard` are both 0.
- R8: After each recovery attempt, the good criteria are applied to the inputs as they are after SETTLE_CYC cycles. A success there gives `done` SETTLE_CYC+2 cycles after the `stat_clr` pulse (OES flag already clear).
- R9: At most MAX_TRIES recovery attempts are made. If the last one is not good, `done` rises with `pass`=0 SETTLE_CYC+1 cycles after the last `stat_clr`.
- R10: Once good, the block waits up to OES_CYC cycles for `oes_flag`=0. On success, `err_stat_clr`, `err_det_clr` and `log_err_clr` pulse in the `done` cycle with `pass`=1. On timeout, `done` comes OES_CYC+2 cycles after start (port good at start) with `pass`=0 and no clears.
- R11: `done` is a single-cycle pulse and `pass` is only high with `done`. A `start` during a running sequence is ignored and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a supervision sequence (taken only when idle) |
| rst_done | input | 1 | SERDES reset has completed |
| port_init | input | 1 | Port reports initialized |
| wide_cfg | input | 1 | 1 = port configured four lanes wide, 0 = one lane |
| trained_width | input | 3 | Width the port trained to; 3'b010 means four lanes |
| oes_flag | input | 1 | Output-error-stopped flag of the port |
| port_disable | output | 1 | Holds the port disabled |
| ob_discard | output | 1 | Discard pending outbound packets |
| lane_rx_rst | output | LANES | Per-lane receiver reset, active high |
| stat_clr | output | 1 | Write-one-to-clear pulse for the port status register |
| err_stat_clr | output | 1 | Clear pulse for the error-status register |
| err_det_clr | output | 1 | Clear pulse for the error-detect register |
| log_err_clr | output | 1 | Clear pulse for the logical-error register |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pass | output | 1 | Result, valid with `done` |

## Verification
The hardest situation to reach is a four-lane port that does report initialized but trains narrow. It has to stay wrong through every retry, so that the attempt limit rather than the poll timeout decides the result.

The bench models the link inside its stimulus loop. It counts the `stat_clr` pulses the block emits and changes `port_init` and the trained-width code only after a chosen number of them. This lets it produce a narrow-but-initialized port, a port that recovers on a given attempt, and a port that never trains, all with scaled-down delay parameters.

// File: rtl/lrs_pkg.sv
// Package: shared state encoding and constants for the link recovery sequencer.
// Assumes: the four-lane trained-width code is fixed at 3'b010.
package lrs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL,
        S_QUIESCE,
        S_RXRST,
        S_RXREL,
        S_STCLR,
        S_SETTLE,
        S_OESW,
        S_DONE
    } lrs_state_t;

    localparam logic [2:0] WIDTH_CODE_WIDE = 3'b010;

    // Largest of six cycle counts, used to size the shared delay counter.
    function automatic int unsigned lrs_max6(
        input int unsigned a, input int unsigned b, input int unsigned c,
        input int unsigned d, input int unsigned e, input int unsigned f);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        if (f > m) m = f;
        return m;
    endfunction

endpackage

// File: rtl/lrs_delay.sv
// Module: loadable down-counter that times every wait of the sequencer.
// Assumes: load value is (duration - 1); expired is high in the last cycle of a wait.
module lrs_delay #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Count down toward zero, reloading at the entry of each timed state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lrs_qualify.sv
// Module: judges whether the port trained acceptably and builds the lane reset mask.
// Assumes: lane 0 is always in use; the remaining lanes are used only in wide mode.
module lrs_qualify #(
    parameter int unsigned LANES = 4
) (
    input  logic             port_init,
    input  logic             wide_cfg,
    input  logic [2:0]       trained_width,
    output logic             good,
    output logic [LANES-1:0] lane_mask
);
    import lrs_pkg::*;

    // A narrow port needs only the initialized bit; a wide one also needs full width.
    always_comb begin
        good = port_init && (!wide_cfg || (trained_width == WIDTH_CODE_WIDE));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign lane_mask[i] = 1'b1;
        end else begin : g_rest
            assign lane_mask[i] = wide_cfg;
        end
    end

endmodule

// File: rtl/link_recover_seq.sv
// Module: supervises serial port training after SERDES reset and runs a bounded
// lane-reset recovery loop when training fails, then waits for the error-stopped
// flag to clear. Assumes: inputs are synchronous to clk, wide_cfg is stable
// during a sequence, and every delay parameter is at least 1.
module link_recover_seq #(
    parameter int unsigned LANES       = 4,
    parameter int unsigned POLL_CYC    = 400000,
    parameter int unsigned QUIESCE_CYC = 10000,
    parameter int unsigned RXRST_CYC   = 20,
    parameter int unsigned RXREL_CYC   = 60,
    parameter int unsigned SETTLE_CYC  = 4800000,
    parameter int unsigned OES_CYC     = 200000000,
    parameter int unsigned MAX_TRIES   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rst_done,
    input  logic             port_init,
    input  logic             wide_cfg,
    input  logic [2:0]       trained_width,
    input  logic             oes_flag,
    output logic             port_disable,
    output logic             ob_discard,
    output logic [LANES-1:0] lane_rx_rst,
    output logic             stat_clr,
    output logic             err_stat_clr,
    output logic             err_det_clr,
    output logic             log_err_clr,
    output logic             done,
    output logic             pass
);
    import lrs_pkg::*;

    localparam int unsigned MAXD = lrs_max6(POLL_CYC, QUIESCE_CYC, RXRST_CYC,
                                            RXREL_CYC, SETTLE_CYC, OES_CYC);
    localparam int unsigned CW   = (MAXD < 2) ? 1 : $clog2(MAXD);
    localparam int unsigned TW   = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES);
    localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);

    lrs_state_t      st_q, st_d;
    logic [TW-1:0]   tries_q, tries_d;
    logic            res_q, res_d;
    logic            ld;
    logic [CW-1:0]   ld_val;
    logic            expired;
    logic            good;
    logic [LANES-1:0] lane_mask;

    lrs_delay #(.CW(CW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    lrs_qualify #(.LANES(LANES)) u_qualify (
        .port_init     (port_init),
        .wide_cfg      (wide_cfg),
        .trained_width (trained_width),
        .good          (good),
        .lane_mask     (lane_mask)
    );

    // Next-state, attempt count, result and timer reload decisions.
    always_comb begin
        st_d    = st_q;
        tries_d = tries_q;
        res_d   = res_q;
        ld      = 1'b0;
        ld_val  = '0;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    if (!rst_done) begin
                        st_d  = S_DONE;
                        res_d = 1'b0;
                    end else begin
                        st_d   = S_POLL;
                        ld     = 1'b1;
                        ld_val = CW'(POLL_CYC - 1);
                    end
                end
            end
            S_POLL: begin
                if (port_init && good) begin
                    st_d   = S_OESW;
                    ld     = 1'b1;
                    ld_val = CW'(OES_CYC - 1);
                end else if (port_init || expired) begin
                    st_d    = S_QUIESCE;
                    tries_d = '0;
                    ld      = 1'b1;
                    ld_val  = CW'(QUIESCE_CYC - 1);
                end
            end
            S_QUIESCE: begin
                if (expired) begin
                    st_d   = S_RXRST;
                    ld     = 1'b1;
                    ld_val = CW'(RXRST_CYC - 1);
                end
            end
            S_RXRST: begin
                if (expired) begin
                    st_d   = S_RXREL;
                    ld     = 1'b1;
                    ld_val = CW'(RXREL_CYC - 1);
                end
            end
            S_RXREL: begin
                if (expired) st_d = S_STCLR;
            end
            S_STCLR: begin
                st_d   = S_SETTLE;
                ld     = 1'b1;
                ld_val = CW'(SETTLE_CYC - 1);
            end
            S_SETTLE: begin
                if (expired) begin
                    if (good) begin
                        st_d   = S_OESW;
                        ld     = 1'b1;
                        ld_val = CW'(OES_CYC - 1);
                    end else if (tries_q == LAST_TRY) begin
                        st_d  = S_DONE;
                        res_d = 1'b0;
                    end else begin
                        st_d    = S_QUIESCE;
                        tries_d = tries_q + 1'b1;
                        ld      = 1'b1;
                        ld_val  = CW'(QUIESCE_CYC - 1);
                    end
                end
            end
            S_OESW: begin
                if (!oes_flag) begin
                    st_d  = S_DONE;
                    res_d = 1'b1;
                end else if (expired) begin
                    st_d  = S_DONE;
                    res_d = 1'b0;
                end
            end
            S_DONE: begin
                st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State, attempt count and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            tries_q <= '0;
            res_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            tries_q <= tries_d;
            res_q   <= res_d;
        end
    end

    // Output decode from the current state.
    always_comb begin
        port_disable = (st_q == S_QUIESCE) || (st_q == S_RXRST) ||
                       (st_q == S_RXREL)   || (st_q == S_STCLR);
        ob_discard   = port_disable;
        lane_rx_rst  = (st_q == S_RXRST) ? lane_mask : '0;
        stat_clr     = (st_q == S_STCLR);
        done         = (st_q == S_DONE);
        pass         = done && res_q;
        err_stat_clr = pass;
        err_det_clr  = pass;
        log_err_clr  = pass;
    end

endmodule

// File: rtl/lrs_checker.sv
// Module: temporal properties of the link recovery sequencer, bound to its top.
// Assumes: observes ports only; clocked on clk with synchronous active-low reset.
module lrs_checker #(
    parameter int unsigned LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wide_cfg,
    input logic             port_disable,
    input logic             ob_discard,
    input logic [LANES-1:0] lane_rx_rst,
    input logic             stat_clr,
    input logic             err_stat_clr,
    input logic             err_det_clr,
    input logic             log_err_clr,
    input logic             done,
    input logic             pass
);

    a_r5_lane_rst_inside_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_rx_rst != '0) |-> (port_disable && ob_discard));

    a_r5_disable_discard_paired: assert property (@(posedge clk) disable iff (!rst_n)
        port_disable == ob_discard);

    a_r6_narrow_upper_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_cfg |-> (lane_rx_rst[LANES-1:1] == '0));

    a_r7_clear_inside_disable: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |-> port_disable);

    a_r7_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (!port_disable && !ob_discard && !stat_clr));

    a_r10_err_clears_with_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stat_clr || err_det_clr || log_err_clr) |->
            (done && pass && err_stat_clr && err_det_clr && log_err_clr));

    a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_pass_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

endmodule

bind link_recover_seq lrs_checker #(.LANES(LANES)) u_lrs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_cfg     (wide_cfg),
    .port_disable (port_disable),
    .ob_discard   (ob_discard),
    .lane_rx_rst  (lane_rx_rst),
    .stat_clr     (stat_clr),
    .err_stat_clr (err_stat_clr),
    .err_det_clr  (err_det_clr),
    .log_err_clr  (log_err_clr),
    .done         (done),
    .pass         (pass)
);

// File: tb/link_recover_seq_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, with the link modelled in the stimulus loop.
module link_recover_seq_bench;

    localparam int unsigned LANES = 4;
    localparam int unsigned P  = 20;
    localparam int unsigned Q  = 8;
    localparam int unsigned RR = 3;
    localparam int unsigned RL = 5;
    localparam int unsigned S  = 12;
    localparam int unsigned O  = 30;
    localparam int unsigned MT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rst_done = 1'b0;
    logic port_init = 1'b0;
    logic wide_cfg = 1'b0;
    logic [2:0] trained_width = 3'b000;
    logic oes_flag = 1'b0;
    logic port_disable, ob_discard, stat_clr;
    logic err_stat_clr, err_det_clr, log_err_clr, done, pass;
    logic [LANES-1:0] lane_rx_rst;

    int n_chk = 0;
    int n_bad = 0;

    // Statistics gathered by run_seq.
    int cyc, n_pd_rise, pd_cycles, pd_disc_mismatch, first_pd_cyc;
    int n_stat, last_stat_cyc, n_err_clr, lane_cycles, n_done;
    logic [LANES-1:0] lane_or;
    logic done_pass, prev_pd;

    always #2.5 clk = ~clk;

    link_recover_seq #(
        .LANES(LANES), .POLL_CYC(P), .QUIESCE_CYC(Q), .RXRST_CYC(RR),
        .RXREL_CYC(RL), .SETTLE_CYC(S), .OES_CYC(O), .MAX_TRIES(MT)
    ) u_link_recover_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rst_done(rst_done),
        .port_init(port_init), .wide_cfg(wide_cfg), .trained_width(trained_width),
        .oes_flag(oes_flag), .port_disable(port_disable), .ob_discard(ob_discard),
        .lane_rx_rst(lane_rx_rst), .stat_clr(stat_clr), .err_stat_clr(err_stat_clr),
        .err_det_clr(err_det_clr), .log_err_clr(log_err_clr), .done(done), .pass(pass)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives one sequence and models the link: after good_after status clears the
    // port reports initialized with width w_after. extra_at re-pulses start mid-run.
    task automatic run_seq(input logic rd, input logic wide, input logic init0,
                           input logic [2:0] w0, input int good_after,
                           input logic [2:0] w_after, input logic oes_hold,
                           input int extra_at);
        @(negedge clk);
        rst_done = rd; wide_cfg = wide; port_init = init0;
        trained_width = w0; oes_flag = oes_hold;
        cyc = 0; n_pd_rise = 0; pd_cycles = 0; pd_disc_mismatch = 0;
        first_pd_cyc = -1; n_stat = 0; last_stat_cyc = -1; n_err_clr = 0;
        lane_cycles = 0; n_done = 0; lane_or = '0; done_pass = 1'b0; prev_pd = 1'b0;
        start = 1'b1;
        while (n_done == 0 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            start = (cyc == extra_at);
            if (port_disable && !prev_pd) begin
                n_pd_rise++;
                if (first_pd_cyc < 0) first_pd_cyc = cyc;
            end
            prev_pd = port_disable;
            if (port_disable) pd_cycles++;
            if (port_disable != ob_discard) pd_disc_mismatch++;
            if (lane_rx_rst != '0) lane_cycles++;
            lane_or |= lane_rx_rst;
            if (err_stat_clr && err_det_clr && log_err_clr) n_err_clr++;
            if (stat_clr) begin
                n_stat++;
                last_stat_cyc = cyc;
                if (good_after > 0 && n_stat >= good_after) begin
                    port_init = 1'b1;
                    trained_width = w_after;
                end
            end
            if (done) begin
                n_done++;
                done_pass = pass;
            end
        end
        start = 1'b0;
        if (n_done == 0) check("watchdog: sequence never finished", 0, 1);
    endtask

    task automatic t_reset_state();
        check("R1 port_disable after reset", port_disable, 0);
        check("R1 ob_discard after reset", ob_discard, 0);
        check("R1 lane_rx_rst after reset", lane_rx_rst, 0);
        check("R1 clears after reset",
              {stat_clr, err_stat_clr, err_det_clr, log_err_clr}, 0);
        check("R1 done/pass after reset", {done, pass}, 0);
    endtask

    task automatic t_no_reset_done();
        run_seq(1'b0, 1'b1, 1'b1, 3'b010, 0, 3'b010, 1'b0, 0);
        check("R2 done cycle", cyc, 1);
        check("R2 pass", done_pass, 0);
        check("R2 no port disable", n_pd_rise, 0);
    endtask

    task automatic t_narrow_good();
        run_seq(1'b1, 1'b0, 1'b1, 3'b000, 0, 3'b000, 1'b0, 0);
        check("R4 narrow good done cycle", cyc, 3);
        check("R4 narrow good pass", done_pass, 1);
        check("R4 no recovery", n_pd_rise, 0);
        check("R10 error clears with pass", n_err_clr, 1);
    endtask

    task automatic t_wide_downtrain_recover();
        run_seq(1'b1, 1'b1, 1'b1, 3'b001, 1, 3'b010, 1'b0, 0);
        check("R4 downtrained wide goes to recovery", n_pd_rise, 1);
        check("R5 disabled span length", pd_cycles, int'(Q + RR + RL + 1));
        check("R5 disable/discard paired", pd_disc_mismatch, 0);
        check("R5 lane reset length", lane_cycles, int'(RR));
        check("R6 wide lane mask", lane_or, 4'b1111);
        check("R7 one status clear", n_stat, 1);
        check("R8 done after settle", cyc - last_stat_cyc, int'(S + 2));
        check("R8 pass after recovery", done_pass, 1);
    endtask

    task automatic t_narrow_timeout_exhaust();
        run_seq(1'b1, 1'b0, 1'b0, 3'b000, 0, 3'b000, 1'b0, 0);
        check("R3 first disable after poll window", first_pd_cyc, int'(P + 1));
        check("R9 attempt count", n_pd_rise, int'(MT));
        check("R7 status clear per attempt", n_stat, int'(MT));
        check("R9 fail result", done_pass, 0);
        check("R9 done after last settle", cyc - last_stat_cyc, int'(S + 1));
        check("R6 narrow lane mask", lane_or, 4'b0001);
        check("R10 no clears on fail", n_err_clr, 0);
    endtask

    task automatic t_narrow_second_try();
        run_seq(1'b1, 1'b0, 1'b0, 3'b000, 2, 3'b000, 1'b0, 0);
        check("R8 pass on second attempt", done_pass, 1);
        check("R8 two attempts", n_pd_rise, 2);
    endtask

    task automatic t_wide_stays_narrow();
        run_seq(1'b1, 1'b1, 1'b1, 3'b001, 1, 3'b001, 1'b0, 0);
        check("R4 narrow width code rejected", done_pass, 0);
        check("R9 attempts with narrow training", n_pd_rise, int'(MT));
    endtask

    task automatic t_oes_timeout();
        run_seq(1'b1, 1'b0, 1'b1, 3'b000, 0, 3'b000, 1'b1, 0);
        check("R10 oes timeout done cycle", cyc, int'(O + 2));
        check("R10 oes timeout fail", done_pass, 0);
        check("R10 no clears on timeout", n_err_clr, 0);
        oes_flag = 1'b0;
    endtask

    task automatic t_start_while_busy();
        int extra_done;
        int extra_pd;
        run_seq(1'b1, 1'b1, 1'b1, 3'b001, 1, 3'b010, 1'b0, 5);
        check("R11 pass despite stray start", done_pass, 1);
        check("R11 single recovery", n_pd_rise, 1);
        extra_done = 0;
        extra_pd = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done) extra_done++;
            if (port_disable) extra_pd++;
        end
        check("R11 no extra done", extra_done, 0);
        check("R11 no restarted sequence", extra_pd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_no_reset_done();
        t_narrow_good();
        t_wide_downtrain_recover();
        t_narrow_timeout_exhaust();
        t_narrow_second_try();
        t_wide_stays_narrow();
        t_oes_timeout();
        t_start_while_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule